// File: doc/BRIEF.md
# Ancillary Packet Admission Filter

This block decides whether an ancillary data packet arriving on a 10-bit word stream may be stored in a downstream packet buffer. The caller raises `pkt_start` together with the packet's data ID word. The next valid word is taken as the secondary data ID. The low bytes of the two identifier words form a 16-bit packet identifier. This identifier is compared against a programmable reference under a programmable don't-care mask.

Each identifier word also carries its own parity bits, and these are checked. The parity check can be switched off. A failed ID match or a parity error rejects the packet. The decision is registered one cycle after the secondary data ID word arrives. Because of this, the buffer logic can gate the payload words that follow. A one-cycle status pulse reports a parity rejection.

Top module: `anc_admit_filter`

## Requirements
- R1: After reset, `admit_valid`, `admit` and `par_err` are 0. The configuration holds mask FFFFh, reference ID 0000h and parity checking enabled. A well-formed packet sent before any configuration write is therefore admitted.
- R2: The configuration registers load `cfg_mask`, `cfg_ref_id` and `cfg_par_bypass` on a clock edge where `cfg_we` is 1. A mask bit of 1 makes the matching reference bit a don't-care. The ID matches when `((id ^ ref) & ~mask) == 0`.
- R3: With mask 0000h, a packet matches only when its ID equals the reference ID in all 16 bits.
- R4: With mask FFFFh, a packet with any ID matches.
- R5: An identifier word is well formed when both of these hold:
  - bit 8 equals the XOR of bits 7:0 (even parity over bits 8:0);
  - bit 9 equals the inverse of bit 8.
- R6: With parity checking enabled, a malformed data ID or secondary data ID word rejects the packet (`admit`=0), whatever the match result. `par_err` is 1 for exactly the one cycle in which that decision first appears.
- R7: With `cfg_par_bypass`=1, parity bits are ignored and `par_err` stays 0. A matching packet with malformed identifier words is admitted.
- R8: `admit_valid` becomes 1 in the cycle after the clock edge that samples the secondary data ID word. `admit` and `admit_valid` then hold unchanged until a word with `pkt_start`=1. That word clears `admit_valid` at the next edge.
- R9: The packet ID is `{data_id[7:0], secondary_id[7:0]}`, with the data ID in the upper byte.
- R10: Words with `word_valid`=0 are ignored. Idle cycles between the two identifier words do not change which word is taken as the secondary data ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | `word_data` carries a word this cycle |
| pkt_start | input | 1 | The current valid word is the data ID word of a new packet |
| word_data | input | 10 | Stream word |
| cfg_we | input | 1 | Load configuration registers |
| cfg_ref_id | input | 16 | Reference packet ID |
| cfg_mask | input | 16 | Don't-care mask, 1 = ignore bit |
| cfg_par_bypass | input | 1 | 1 = skip identifier parity checking |
| admit_valid | output | 1 | Decision for the current packet is available |
| admit | output | 1 | Packet may be loaded into the buffer |
| par_err | output | 1 | One-cycle pulse: packet rejected on identifier parity |

## Verification
The decision and the parity pulse pass through one register stage. They are due in the cycle after the edge that samples the secondary data ID word. The bench drives inputs on falling edges and reads the outputs on the falling edge right after that sampling edge. It reads them again two cycles later to confirm that the decision holds and the pulse has ended.

Configuration writes take effect at the edge where they are sampled. Each write completes before the next packet begins. The match sweep covers the exact reference and every single-bit deviation from it under several masks. The parity sweep corrupts bit 8 or bit 9 of each identifier word, with the check enabled and disabled.

// File: rtl/anc_filter_pkg.sv
package anc_filter_pkg;
  parameter int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 2;
  localparam int ID_W   = 2 * BYTE_W;

  typedef enum logic {ST_IDLE, ST_HAVE_DID} seq_state_t;

  function automatic logic word_form_ok(input logic [WORD_W-1:0] w);
    logic p;
    p = ^w[BYTE_W-1:0];
    return (w[BYTE_W] == p) && (w[BYTE_W+1] == ~p);
  endfunction

  function automatic logic id_masked_match(input logic [ID_W-1:0] id,
                                           input logic [ID_W-1:0] ref_id,
                                           input logic [ID_W-1:0] dc_mask);
    return ((id ^ ref_id) & ~dc_mask) == '0;
  endfunction
endpackage

// File: rtl/anc_cfg_regs.sv
module anc_cfg_regs
  import anc_filter_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] ref_in,
  input  logic [ID_W-1:0] mask_in,
  input  logic            bypass_in,
  output logic [ID_W-1:0] ref_q,
  output logic [ID_W-1:0] mask_q,
  output logic            bypass_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q    <= '0;
      mask_q   <= '1;
      bypass_q <= 1'b0;
    end else if (we) begin
      ref_q    <= ref_in;
      mask_q   <= mask_in;
      bypass_q <= bypass_in;
    end
  end
endmodule

// File: rtl/anc_word_check.sv
module anc_word_check
  import anc_filter_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              bypass,
  output logic              ok
);
  assign ok = bypass | word_form_ok(word);
endmodule

// File: rtl/anc_id_seq.sv
module anc_id_seq
  import anc_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic              pkt_start,
  input  logic [WORD_W-1:0] word_data,
  output logic [WORD_W-1:0] did_q,
  output logic              start_evt,
  output logic              sdid_evt
);
  seq_state_t state_q;

  assign start_evt = word_valid & pkt_start;
  assign sdid_evt  = word_valid & ~pkt_start & (state_q == ST_HAVE_DID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      did_q   <= '0;
    end else if (start_evt) begin
      state_q <= ST_HAVE_DID;
      did_q   <= word_data;
    end else if (sdid_evt) begin
      state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/anc_admit_filter.sv
module anc_admit_filter
  import anc_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic              pkt_start,
  input  logic [WORD_W-1:0] word_data,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_ref_id,
  input  logic [ID_W-1:0]   cfg_mask,
  input  logic              cfg_par_bypass,
  output logic              admit_valid,
  output logic              admit,
  output logic              par_err
);
  logic [ID_W-1:0]   ref_q, mask_q;
  logic              bypass_q;
  logic [WORD_W-1:0] did_q;
  logic              start_evt, sdid_evt;
  logic [WORD_W-1:0] id_words [2];
  logic [1:0]        word_ok;
  logic              words_ok, id_hit;
  logic [ID_W-1:0]   pkt_id;

  anc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .ref_in(cfg_ref_id), .mask_in(cfg_mask), .bypass_in(cfg_par_bypass),
    .ref_q(ref_q), .mask_q(mask_q), .bypass_q(bypass_q)
  );

  anc_id_seq u_seq (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .pkt_start(pkt_start),
    .word_data(word_data), .did_q(did_q), .start_evt(start_evt), .sdid_evt(sdid_evt)
  );

  assign id_words[0] = did_q;
  assign id_words[1] = word_data;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    anc_word_check u_wc (.word(id_words[g]), .bypass(bypass_q), .ok(word_ok[g]));
  end

  assign pkt_id   = {did_q[BYTE_W-1:0], word_data[BYTE_W-1:0]};
  assign words_ok = &word_ok;
  assign id_hit   = id_masked_match(pkt_id, ref_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      admit_valid <= 1'b0;
      admit       <= 1'b0;
      par_err     <= 1'b0;
    end else begin
      par_err <= 1'b0;
      if (start_evt) begin
        admit_valid <= 1'b0;
        admit       <= 1'b0;
      end else if (sdid_evt) begin
        admit_valid <= 1'b1;
        admit       <= id_hit & words_ok;
        par_err     <= ~words_ok;
      end
    end
  end
endmodule

// File: rtl/anc_admit_filter_chk.sv
module anc_admit_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic sdid_evt,
  input logic bypass_q,
  input logic admit_valid,
  input logic admit,
  input logic par_err
);
  a_r8_decide_next: assert property (@(posedge clk) disable iff (!rst_n)
    sdid_evt |=> admit_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (admit_valid && !start_evt) |=> (admit_valid && $stable(admit)));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !admit_valid);

  a_r6_perr_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (admit_valid && !admit));

  a_r6_perr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);

  a_r7_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sdid_evt && bypass_q) |=> !par_err);
endmodule

bind anc_admit_filter anc_admit_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .sdid_evt(sdid_evt),
  .bypass_q(bypass_q), .admit_valid(admit_valid), .admit(admit), .par_err(par_err)
);

// File: tb/anc_admit_filter_tb_top.sv
module anc_admit_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0, pkt_start = 1'b0, cfg_we = 1'b0, cfg_par_bypass = 1'b0;
  logic [9:0]  word_data = '0;
  logic [15:0] cfg_ref_id = '0, cfg_mask = '0;
  logic admit_valid, admit, par_err;
  int checks = 0, failures = 0, cycles = 0;
  logic [15:0] cur_ref = 16'h0000, cur_mask = 16'hFFFF;
  logic cur_byp = 1'b0;

  always #10 clk = ~clk;

  anc_admit_filter dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .pkt_start(pkt_start),
    .word_data(word_data), .cfg_we(cfg_we), .cfg_ref_id(cfg_ref_id), .cfg_mask(cfg_mask),
    .cfg_par_bypass(cfg_par_bypass), .admit_valid(admit_valid), .admit(admit), .par_err(par_err)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {valid,admit,perr} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // bad = 0 clean, 1 bit8 flipped, 2 bit9 flipped
  function automatic logic [9:0] mk(input logic [7:0] b, input int bad);
    logic p;
    p = (b[0]^b[1]^b[2]^b[3]^b[4]^b[5]^b[6]^b[7]) ^ (bad == 1);
    return {(~p) ^ (bad == 2), p, b};
  endfunction

  task automatic set_cfg(input logic [15:0] r, input logic [15:0] m, input logic byp);
    @(negedge clk);
    cfg_we = 1; cfg_ref_id = r; cfg_mask = m; cfg_par_bypass = byp;
    @(negedge clk);
    cfg_we = 0; cfg_ref_id = ~r; cfg_mask = ~m; cfg_par_bypass = ~byp;
    cur_ref = r; cur_mask = m; cur_byp = byp;
  endtask

  task automatic send(input string req, input logic [15:0] id, input int bad_d,
                      input int bad_s, input int gaps);
    logic hit, pok;
    logic [2:0] exp;
    @(negedge clk);
    word_valid = 1; pkt_start = 1; word_data = mk(id[15:8], bad_d);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      word_valid = 0; pkt_start = 1; word_data = 10'h3FF;
    end
    @(negedge clk);
    word_valid = 1; pkt_start = 0; word_data = mk(id[7:0], bad_s);
    @(negedge clk);
    word_valid = 0; word_data = mk(id[7:0] ^ 8'hFF, 0);
    hit = (((id ^ cur_ref) & ~cur_mask) == 16'h0);
    pok = cur_byp || (bad_d == 0 && bad_s == 0);
    exp = {1'b1, hit & pok, ~pok};
    check(req, {admit_valid, admit, par_err}, exp);
    @(negedge clk);
    word_valid = 1; pkt_start = 0; word_data = mk(id[15:8] ^ 8'h5A, 0);
    @(negedge clk);
    word_valid = 0;
    check("R8 hold", {admit_valid, admit, par_err}, {exp[2:1], 1'b0});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] masks [5];
    logic [15:0] refs [2];
    masks = '{16'hFFFF, 16'h0000, 16'h00FF, 16'hF0F0, 16'h0001};
    refs = '{16'h0000, 16'hA5C3};
    repeat (3) @(negedge clk);
    check("R1 reset", {admit_valid, admit, par_err}, 3'b000);
    rst_n = 1;
    send("R1 default admits", 16'h1234, 0, 0, 0);
    send("R1 default parity on", 16'h1234, 1, 0, 0);
    send("R10 idle gap", 16'h8421, 0, 0, 3);
    foreach (masks[mi]) foreach (refs[ri]) begin
      set_cfg(refs[ri], masks[mi], 1'b0);
      for (int k = 0; k <= 16; k++) begin
        logic [15:0] id;
        id = (k == 16) ? refs[ri] : refs[ri] ^ (16'h1 << k);
        if (masks[mi] == 16'h0000) send("R3 exact", id, 0, 0, k % 2);
        else if (masks[mi] == 16'hFFFF) send("R4 any", id, 0, 0, 0);
        else send("R2 R9 masked", id, 0, 0, 0);
      end
    end
    for (int byp = 0; byp < 2; byp++) begin
      set_cfg(16'h3C69, 16'h0000, byp[0]);
      for (int bd = 0; bd < 3; bd++)
        for (int bs = 0; bs < 3; bs++)
          send(byp ? "R7 bypass" : "R5 R6 parity", 16'h3C69, bd, bs, 0);
      send(byp ? "R7 miss" : "R6 miss", 16'h3C68, 1, 0, 0);
    end
    @(negedge clk);
    word_valid = 1; pkt_start = 1; word_data = mk(8'h11, 0);
    @(negedge clk);
    word_valid = 0; pkt_start = 0;
    check("R8 start clears", {admit_valid, admit, par_err}, 3'b000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule